// File: doc/BRIEF.md
# Pattern-Memory Swizzle Crossbar

This block reorders the elements of a vector in a single pass. A vector of N 16-bit elements enters as one beat. Each output element takes a copy of any one input element, or it is forced to zero. The routing is not driven per cycle on wide control wires. Instead, a small local store keeps several complete routing patterns, and each beat carries only the index of the stored pattern it wants. Because a pattern is just a choice of source per output, the same source may feed many outputs. The block therefore covers arbitrary permutations and also broadcast and multicast shuffles.

Patterns are written at run time through a configuration port, one whole slot per write. Software can therefore load shuffles that nobody foresaw when the hardware was built. Only the slots that are resident can be used; any other shuffle needs a reload first. A beat may name a different slot from the beat before it, and this costs no cycle. The shuffled vector is held in one output register.

Data moves by valid/ready on both sides. A beat is taken when `in_valid` and `in_ready` are both high at a rising edge. The result is presented with `out_valid` after that edge. While `out_valid` is high and `out_ready` is low, the output holds unchanged and `in_ready` stays low. When the output is drained or empty, `in_ready` is high, so a new beat can enter in the same cycle as the old one leaves.

Top module: `swz_crossbar`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and every slot holds all-disabled entries, so a beat that uses any slot before it is written produces an all-zero vector.
- R2: Element k of `cfg_pattern` is bits [k*4 +: 4] at the default N=8. Bit 3 is the enable bit and bits 2:0 are the source index. For an enabled entry with source s, output element k (bits [k*16 +: 16] of `out_data`) equals input element s of the accepted beat.
- R3: Several entries of one pattern may name the same source, and each of those outputs then carries a copy of that input element.
- R4: An entry whose enable bit is 0 drives its output element to zero.
- R5: Each beat uses the slot named by `in_sel` in its accept cycle. Consecutive beats may name different slots, and one beat is still accepted every cycle while `out_ready` is high.
- R6: A beat accepted at a rising edge shows `out_valid` high after that same edge, which is one register of latency.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: A write through `cfg_we`/`cfg_slot`/`cfg_pattern` takes effect for beats accepted at later edges. A beat accepted at the same edge as a write to its own slot uses the old pattern, and the output it already holds is never changed by the write.
- R9: A write to one slot leaves the patterns in all other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | N*16 | Input vector, element k at [k*16 +: 16] |
| in_sel | input | SLOT_W | Pattern slot used by this beat |
| out_valid | output | 1 | Output vector is present |
| out_ready | input | 1 | Consumer takes the output vector |
| out_data | output | N*16 | Shuffled vector |
| cfg_we | input | 1 | Write one pattern slot |
| cfg_slot | input | SLOT_W | Slot to write |
| cfg_pattern | input | N*(IDX_W+1) | Pattern, one enable bit and source index per output |

## Verification
The bench tries the shuffle with four fixed patterns. A full reversal shows that each output reads its own source and not a neighbour's. A one-source broadcast covers multicast. A half-disabled pattern separates zero forcing from routing. Identity follows, with the four run back to back to show that changing slots between beats costs no cycle. Directed cases then stall the output under back-pressure, write a slot in the same cycle as a beat that uses it, and rewrite one slot while another stays in use. These cases separate old-pattern from new-pattern behaviour and show that slots do not leak into each other. Long random runs then mix random patterns, with random enables and repeated sources, random slot choice, random config writes and random `out_ready` against a pattern model kept in the bench.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int ELEM_W = 16;
endpackage

// File: rtl/swz_pattern_store.sv
module swz_pattern_store #(
  parameter int N      = 8,
  parameter int SLOTS  = 4,
  parameter int EW     = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [N*EW-1:0]   wr_pat,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [N*EW-1:0]   rd_pat
);
  logic [N*EW-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr_en && int'(wr_slot) == s)
        slot_q[s] <= wr_pat;
    end
  end

  always_comb begin
    rd_pat = '0;
    for (int s = 0; s < SLOTS; s++)
      if (int'(rd_slot) == s) rd_pat = slot_q[s];
  end
endmodule

// File: rtl/swz_xbar.sv
module swz_xbar #(
  parameter int N     = 8,
  parameter int EW    = 4,
  parameter int IDX_W = 3
) (
  input  logic [N*swz_pkg::ELEM_W-1:0] in_data,
  input  logic [N*EW-1:0]              pat,
  output logic [N*swz_pkg::ELEM_W-1:0] out_data
);
  localparam int EL = swz_pkg::ELEM_W;

  logic [EL-1:0] lane_in [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign lane_in[i] = in_data[i*EL +: EL];
  end

  for (genvar k = 0; k < N; k++) begin : g_out
    logic [IDX_W-1:0] src;
    logic             en;
    assign src = pat[k*EW +: IDX_W];
    assign en  = pat[k*EW + EW - 1];
    always_comb begin
      out_data[k*EL +: EL] = '0;
      for (int i = 0; i < N; i++)
        if (en && int'(src) == i) out_data[k*EL +: EL] = lane_in[i];
    end
  end
endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/swz_crossbar.sv
module swz_crossbar #(
  parameter int N      = 8,
  parameter int SLOTS  = 4,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1,
  parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [N*swz_pkg::ELEM_W-1:0]   in_data,
  input  logic [SLOT_W-1:0]              in_sel,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [N*swz_pkg::ELEM_W-1:0]   out_data,
  input  logic                           cfg_we,
  input  logic [SLOT_W-1:0]              cfg_slot,
  input  logic [N*(IDX_W+1)-1:0]         cfg_pattern
);
  localparam int EW = IDX_W + 1;
  localparam int DW = N * swz_pkg::ELEM_W;

  logic [N*EW-1:0] act_pat;
  logic [DW-1:0]   shuf;

  swz_pattern_store #(.N(N), .SLOTS(SLOTS), .EW(EW), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_slot(cfg_slot), .wr_pat(cfg_pattern),
    .rd_slot(in_sel), .rd_pat(act_pat)
  );

  swz_xbar #(.N(N), .EW(EW), .IDX_W(IDX_W)) u_xbar (
    .in_data(in_data), .pat(act_pat), .out_data(shuf)
  );

  swz_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(shuf),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/swz_crossbar_chk.sv
module swz_crossbar_chk #(
  parameter int N  = 8,
  parameter int EW = 4,
  parameter int DW = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_data,
  input logic [N*EW-1:0] act_pat,
  input logic [DW-1:0]   shuf
);
  localparam int EL = swz_pkg::ELEM_W;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_empty_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  for (genvar k = 0; k < N; k++) begin : g_lane
    p_off_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !act_pat[k*EW + EW - 1] |-> (shuf[k*EL +: EL] == '0));
  end
endmodule

bind swz_crossbar swz_crossbar_chk #(
  .N(N), .EW(IDX_W + 1), .DW(N * swz_pkg::ELEM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .act_pat(act_pat), .shuf(shuf)
);

// File: tb/tb_swz_crossbar.sv
module tb_swz_crossbar;
  localparam int CLK_P  = 10;
  localparam int N      = 8;
  localparam int SLOTS  = 4;
  localparam int IDX_W  = 3;
  localparam int SLOT_W = 2;
  localparam int EW     = IDX_W + 1;
  localparam int EL     = 16;
  localparam int DW     = N * EL;
  localparam int PW     = N * EW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, cfg_we = 0;
  logic in_ready, out_valid;
  logic [DW-1:0] in_data = '0, out_data;
  logic [SLOT_W-1:0] in_sel = '0, cfg_slot = '0;
  logic [PW-1:0] cfg_pattern = '0;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string cur_tag = "R2";

  logic [PW-1:0] model [SLOTS];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  bit stall_pend = 0, acc_prev = 0;
  logic [DW-1:0] stall_data;

  always #(CLK_P/2) clk = ~clk;

  swz_crossbar #(.N(N), .SLOTS(SLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sel(in_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_pattern(cfg_pattern)
  );

  function automatic logic [DW-1:0] shuffle(logic [DW-1:0] d, logic [PW-1:0] p);
    logic [DW-1:0] r = '0;
    for (int k = 0; k < N; k++) begin
      logic [EW-1:0] e = p[k*EW +: EW];
      if (e[EW-1]) r[k*EL +: EL] = d[int'(e[IDX_W-1:0])*EL +: EL];
    end
    return r;
  endfunction

  function automatic logic [EW-1:0] ent(bit en, int src);
    return {en, 3'(src)};
  endfunction

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] r;
    for (int i = 0; i < DW/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    #(CLK_P/2 - 1);
    if (stall_pend) chk(out_valid && out_data == stall_data, "R7", out_data, stall_data);
    if (out_valid && !out_ready) chk(!in_ready, "R7", DW'(in_ready), '0);
    if (acc_prev) chk(out_valid, "R6", DW'(out_valid), DW'(1));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R6", out_data, '0);
      else begin
        logic [DW-1:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        chk(out_data == e, t, out_data, e);
      end
    end
    stall_pend = out_valid && !out_ready;
    stall_data = out_data;
    acc_prev = in_valid && in_ready;
    if (acc_prev) begin
      exp_q.push_back(shuffle(in_data, model[in_sel]));
      tag_q.push_back(cur_tag);
    end
    if (cfg_we) model[cfg_slot] = cfg_pattern;
    @(negedge clk);
    cycles++;
  endtask

  task automatic write_slot(int s, logic [PW-1:0] p);
    cfg_we = 1; cfg_slot = SLOT_W'(s); cfg_pattern = p;
    step();
    cfg_we = 0;
  endtask

  task automatic beat(int s, logic [DW-1:0] d);
    in_valid = 1; in_sel = SLOT_W'(s); in_data = d;
    step();
    in_valid = 0;
  endtask

  initial begin
    if (!done) begin
      while (cycles < 150000 && !done) @(negedge clk);
      if (!done) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [PW-1:0] p;
    void'($urandom(32'd20240517));
    for (int s = 0; s < SLOTS; s++) model[s] = '0;
    #(CLK_P*2 + 3);
    rst_n = 1;
    @(negedge clk);
    #(CLK_P/2 - 1);
    chk(!out_valid && in_ready, "R1", DW'({out_valid, in_ready}), DW'(1));
    @(negedge clk);

    // R1: unwritten slots yield zero
    out_ready = 1;
    cur_tag = "R1";
    beat(2, rnd_data());
    beat(0, rnd_data());

    // load four patterns
    for (int k = 0; k < N; k++) p[k*EW +: EW] = ent(1, N-1-k);
    write_slot(0, p);
    for (int k = 0; k < N; k++) p[k*EW +: EW] = ent(1, 3);
    write_slot(1, p);
    for (int k = 0; k < N; k++) p[k*EW +: EW] = ent(k % 2, k);
    write_slot(2, p);
    for (int k = 0; k < N; k++) p[k*EW +: EW] = ent(1, k);
    write_slot(3, p);

    // R5: back-to-back beats switching slot each cycle
    cur_tag = "R2"; beat(0, rnd_data());
    in_valid = 1;
    cur_tag = "R3"; in_sel = 1; in_data = rnd_data(); step();
    cur_tag = "R4"; in_sel = 2; in_data = rnd_data(); step();
    cur_tag = "R5"; in_sel = 3; in_data = rnd_data(); step();
    chk(in_ready, "R5", DW'(in_ready), DW'(1));
    in_sel = 0; in_data = rnd_data(); step();
    in_valid = 0;
    step();

    // R7: back-pressure hold
    out_ready = 0;
    cur_tag = "R7";
    beat(1, rnd_data());
    in_valid = 1; in_sel = 0; in_data = rnd_data();
    repeat (4) step();
    out_ready = 1;
    step(); step();
    in_valid = 0;
    step();

    // R8: write slot 3 in the same cycle a beat uses it
    for (int k = 0; k < N; k++) p[k*EW +: EW] = ent(1, (k + 1) % N);
    cur_tag = "R8";
    in_valid = 1; in_sel = 3; in_data = rnd_data();
    cfg_we = 1; cfg_slot = 3; cfg_pattern = p;
    step();
    cfg_we = 0;
    in_data = rnd_data();
    step();
    in_valid = 0;
    // R8: write during a held output does not alter it
    out_ready = 0;
    beat(3, rnd_data());
    write_slot(3, '0);
    out_ready = 1;
    step();

    // R9: rewrite slot 0, slot 1 keeps broadcast
    write_slot(0, '0);
    cur_tag = "R9";
    beat(1, rnd_data());
    beat(2, rnd_data());
    step();

    // random phase
    cur_tag = "R2";
    for (int c = 0; c < 3000; c++) begin
      in_valid  = ($urandom % 4) != 0;
      in_sel    = SLOT_W'($urandom);
      in_data   = rnd_data();
      out_ready = ($urandom % 3) != 0;
      cfg_we    = ($urandom % 8) == 0;
      cfg_slot  = SLOT_W'($urandom);
      for (int k = 0; k < N; k++)
        cfg_pattern[k*EW +: EW] = ent(($urandom % 5) != 0, $urandom % N);
      step();
    end
    in_valid = 0; cfg_we = 0; out_ready = 1;
    repeat (3) step();
    chk(exp_q.size() == 0 && !out_valid, "R6", DW'(exp_q.size()), '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule